// File: doc/BRIEF.md
# Cell-Paced Transmit Read Requester

This block issues bus-master read requests for outgoing cell payload, paced by a fixed cell-time grid. A free-running slot timer divides time into slots of `SLOT_CYCLES` clocks. A fetch may begin only on a slot boundary. Each cell is `CELL_WORDS` 32-bit words, and each cell is fetched as one or more word bursts through a request/grant handshake with a bus arbiter. The responder then strobes each word as it completes.

The block has two pacing modes. In single-cell mode it fetches one cell per slot. In grouped mode it fetches N cells back to back, then waits N further slot boundaries before the next group may begin. Burst length is limited by a configured cache-line size, unless the force-full bit is set. A latency-timer expiry closes the current burst early, and the rest of the cell is then requested as a new burst. While no work is pending, no fetch starts, but the slot timer keeps running so that later fetches stay on the grid.

The controller has three states:

- IDLE waits for a permitted slot boundary, then moves to REQ.
- REQ holds the request until it is granted, then moves to XFER.
- XFER counts word strobes. It moves:
  - back to REQ when a burst ends, when the latency timer expires, or when a cell ends with more cells left in the group;
  - to IDLE when the last word of the group is accepted.

Top module: `cell_paced_reader`

## Requirements
- R1: A fetch group starts only on a slot boundary, so the spacing between group starts is always a non-zero multiple of 36 clocks (default `SLOT_CYCLES`).
- R2: With the group field equal to 0 (single-cell mode), one cell is fetched per slot. When a cell completes within its slot, consecutive starts are exactly 36 clocks apart.
- R3: A group field value v from 1 to 7 selects N = min(v, 5) cells. The N cells are fetched back to back. The next start is at the first slot boundary after the group completes, plus N further slots.
- R4: Every cell is 12 words. Each burst requests min(words left in cell, cut) words. The cut is the configured line size when that size is between 1 and 11, and 12 when the line size is 0 or at least 12.
- R5: When the force-full bit is 1, the cut is 12 whatever the line size.
- R6: When latency expiry is high in XFER, the burst ends after any word strobed in that cycle. The remaining words of the cell are requested in a new burst whose length is computed afresh.
- R7: `bus_req` stays high, with `bus_len` stable, until `bus_gnt` is seen. It is low in the cycle after the grant.
- R8: `cell_done` is a one-cycle pulse in the cycle after the 12th word of a cell is accepted, and it is low at every other time.
- R9: While `work_pending` is low at a slot boundary, no fetch starts. Starts made afterwards remain on the 36-clock grid.
- R10: During reset, `bus_req` and `cell_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_group | input | 3 | Group size code: 0 for single cell, 1 to 7 for min(v,5) cells |
| cfg_line_words | input | 4 | Cache-line size in words, used as the burst cut |
| cfg_force_full | input | 1 | Ignore the line size and issue full-cell bursts |
| work_pending | input | 1 | Transmit data is waiting to be fetched |
| bus_req | output | 1 | Burst request to the arbiter |
| bus_len | output | 4 | Word count of the requested burst |
| bus_gnt | input | 1 | Arbiter grant for the pending request |
| word_stb | input | 1 | One word of the current burst has been transferred |
| lat_expire | input | 1 | Latency timer expired; end the current burst |
| cell_done | output | 1 | Pulse after the last word of a cell |

## Verification
Embedded assertions check the following on every cycle:

- the request handshake holds its request and length until grant and drops the request after it;
- requested lengths stay within bounds;
- `cell_done` never lasts two cycles;
- a latency expiry leads straight to a new request;
- every fetch start falls on a slot tick and while work is pending.

Some behaviour only the bench scenarios can show. These are:

- the exact start-to-start spacing in single and grouped modes;
- the saturation of the group code;
- the burst-length sequence for each line size, force setting and latency split;
- that `cell_done` marks exactly the 12th word.

A scoreboard compares each granted length with its expected value.

// File: rtl/cell_pace_pkg.sv
package cell_pace_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/cpr_slot_timer.sv
module cpr_slot_timer #(
    parameter int SLOT_CYCLES = 36,
    localparam int SLOT_W = $clog2(SLOT_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_tick
);
    logic [SLOT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == SLOT_W'(SLOT_CYCLES - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + SLOT_W'(1);
        end
    end

    always_comb slot_tick = (cnt_q == '0);

    // R1: ticks are isolated, one per slot
    a_r1_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        slot_tick |=> !slot_tick);
    a_r1_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < SLOT_W'(SLOT_CYCLES));
endmodule

// File: rtl/cpr_gap_gate.sv
module cpr_gap_gate #(
    parameter int MAX_GROUP = 5,
    localparam int GRP_W = $clog2(MAX_GROUP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_tick,
    input  logic             idle,
    input  logic             work_pending,
    input  logic             group_end,
    input  logic [GRP_W-1:0] gap_slots,
    output logic             start
);
    logic [GRP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (group_end) begin
            gap_q <= gap_slots;
        end else if (slot_tick && idle && gap_q != '0) begin
            gap_q <= gap_q - GRP_W'(1);
        end
    end

    always_comb start = slot_tick && idle && work_pending && (gap_q == '0);

    // R3: the idle gap only shrinks, one slot at a time
    a_r3_gap_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q != '0) && !group_end |=> (gap_q == $past(gap_q)) || (gap_q == $past(gap_q) - GRP_W'(1)));
endmodule

// File: rtl/cpr_fetch_fsm.sv
module cpr_fetch_fsm
    import cell_pace_pkg::*;
#(
    parameter int CELL_WORDS = 12,
    parameter int MAX_GROUP = 5,
    parameter int GRP_CODE_W = 3,
    localparam int WCNT_W = $clog2(CELL_WORDS + 1),
    localparam int GRP_W = $clog2(MAX_GROUP + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [GRP_CODE_W-1:0] cfg_group,
    input  logic [WCNT_W-1:0]     cfg_line_words,
    input  logic                  cfg_force_full,
    input  logic                  bus_gnt,
    input  logic                  word_stb,
    input  logic                  lat_expire,
    output logic                  bus_req,
    output logic [WCNT_W-1:0]     bus_len,
    output logic                  cell_done,
    output logic                  idle,
    output logic                  group_end,
    output logic [GRP_W-1:0]      gap_slots
);
    fetch_state_e state_q, state_d;
    logic [GRP_W-1:0]  cells_left_q;
    logic [WCNT_W-1:0] words_left_q, burst_left_q, cut_q;
    logic              done_q;
    logic              last_word, last_cell;

    function automatic logic [GRP_W-1:0] group_size(input logic [GRP_CODE_W-1:0] code);
        if (int'(code) >= MAX_GROUP) return GRP_W'(MAX_GROUP);
        return GRP_W'(code);
    endfunction

    function automatic logic [WCNT_W-1:0] cut_words(input logic [WCNT_W-1:0] line,
                                                     input logic force_full);
        if (force_full || line == '0 || int'(line) >= CELL_WORDS) return WCNT_W'(CELL_WORDS);
        return line;
    endfunction

    always_comb begin
        last_word = word_stb && (words_left_q == WCNT_W'(1));
        last_cell = (cells_left_q == GRP_W'(1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_REQ;
            ST_REQ:  if (bus_gnt) state_d = ST_XFER;
            ST_XFER: begin
                if (last_word) begin
                    state_d = last_cell ? ST_IDLE : ST_REQ;
                end else if ((word_stb && burst_left_q == WCNT_W'(1)) || lat_expire) begin
                    state_d = ST_REQ;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells_left_q <= '0;
            words_left_q <= '0;
            burst_left_q <= '0;
            cut_q        <= '0;
            gap_slots    <= '0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        gap_slots    <= group_size(cfg_group);
                        cells_left_q <= (group_size(cfg_group) == '0) ? GRP_W'(1)
                                                                      : group_size(cfg_group);
                        words_left_q <= WCNT_W'(CELL_WORDS);
                        cut_q        <= cut_words(cfg_line_words, cfg_force_full);
                    end
                end
                ST_REQ: begin
                    if (bus_gnt) burst_left_q <= bus_len;
                end
                ST_XFER: begin
                    if (word_stb) begin
                        words_left_q <= words_left_q - WCNT_W'(1);
                        burst_left_q <= burst_left_q - WCNT_W'(1);
                    end
                    if (last_word) begin
                        done_q       <= 1'b1;
                        cells_left_q <= cells_left_q - GRP_W'(1);
                        words_left_q <= WCNT_W'(CELL_WORDS);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        bus_req   = (state_q == ST_REQ);
        idle      = (state_q == ST_IDLE);
        bus_len   = (words_left_q < cut_q) ? words_left_q : cut_q;
        cell_done = done_q;
        group_end = (state_q == ST_XFER) && last_word && last_cell;
    end

    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req && $stable(bus_len));
    a_r7_req_release: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt |=> !bus_req);
    a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_len != '0) && (bus_len <= WCNT_W'(CELL_WORDS)));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cell_done |=> !cell_done);
    a_r6_lat_rerequest: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) && lat_expire && !last_word |=> bus_req);
endmodule

// File: rtl/cell_paced_reader.sv
module cell_paced_reader #(
    parameter int SLOT_CYCLES = 36,
    parameter int CELL_WORDS = 12,
    parameter int MAX_GROUP = 5,
    parameter int GRP_CODE_W = 3,
    localparam int WCNT_W = $clog2(CELL_WORDS + 1),
    localparam int GRP_W = $clog2(MAX_GROUP + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [GRP_CODE_W-1:0] cfg_group,
    input  logic [WCNT_W-1:0]     cfg_line_words,
    input  logic                  cfg_force_full,
    input  logic                  work_pending,
    output logic                  bus_req,
    output logic [WCNT_W-1:0]     bus_len,
    input  logic                  bus_gnt,
    input  logic                  word_stb,
    input  logic                  lat_expire,
    output logic                  cell_done
);
    logic             slot_tick, fsm_idle, fetch_start, group_end;
    logic [GRP_W-1:0] gap_slots;

    cpr_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick));

    cpr_gap_gate #(.MAX_GROUP(MAX_GROUP)) u_gate (
        .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .idle(fsm_idle),
        .work_pending(work_pending), .group_end(group_end),
        .gap_slots(gap_slots), .start(fetch_start));

    cpr_fetch_fsm #(.CELL_WORDS(CELL_WORDS), .MAX_GROUP(MAX_GROUP),
                    .GRP_CODE_W(GRP_CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(fetch_start),
        .cfg_group(cfg_group), .cfg_line_words(cfg_line_words),
        .cfg_force_full(cfg_force_full), .bus_gnt(bus_gnt),
        .word_stb(word_stb), .lat_expire(lat_expire),
        .bus_req(bus_req), .bus_len(bus_len), .cell_done(cell_done),
        .idle(fsm_idle), .group_end(group_end), .gap_slots(gap_slots));

    // R1: leaving IDLE happens only on a slot tick
    a_r1_start_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && $past(fsm_idle) |-> $past(slot_tick));
    // R9: leaving IDLE requires pending work
    a_r9_start_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && $past(fsm_idle) |-> $past(work_pending));
endmodule

// File: tb/tb_cell_paced_reader.sv
module tb_cell_paced_reader;
    localparam int SLOT = 36;
    localparam int CW = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_group = '0;
    logic [3:0] cfg_line_words = 4'd4;
    logic       cfg_force_full = 1'b0;
    logic       work_pending = 1'b0;
    logic       bus_req, cell_done;
    logic [3:0] bus_len;
    logic       bus_gnt = 1'b0, word_stb = 1'b0, lat_expire = 1'b0;

    always #2 clk = ~clk;

    cell_paced_reader dut (
        .clk(clk), .rst_n(rst_n), .cfg_group(cfg_group),
        .cfg_line_words(cfg_line_words), .cfg_force_full(cfg_force_full),
        .work_pending(work_pending), .bus_req(bus_req), .bus_len(bus_len),
        .bus_gnt(bus_gnt), .word_stb(word_stb), .lat_expire(lat_expire),
        .cell_done(cell_done));

    int checks = 0, fails = 0;
    int exp_q[$];
    int ncyc = 0;
    int burst_tb = 0, cell_words = CW, grp_words = 0, lat_at = 0;
    int gnt_lag = 0, lag_cnt = 0, held_len = 0;
    int done_cnt = 0, target = 0, cells_in_grp = 0;
    int last_start = 0, last_done_n = 0, prev_n = 0, req_rises = 0;
    bit have_start = 0, exact_ok = 0, run_done = 0, req_prev = 0, last_of_cell = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int grp_of(input int code);
        if (code == 0) return 0;
        return (code > 5) ? 5 : code;
    endfunction

    // monitor, responder and scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            ncyc++;
            if (ncyc > 100000) begin
                fails++;
                $display("FAIL watchdog: actual %0d expected <100000 cycles", ncyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
            if (word_stb) begin
                chk(cell_done == last_of_cell, "R8", "cell_done after word",
                    int'(cell_done), int'(last_of_cell));
                if (last_of_cell) begin
                    cell_words = CW;
                    done_cnt++;
                    cells_in_grp++;
                    last_done_n = ncyc;
                    if (done_cnt == target) begin
                        work_pending = 1'b0;
                        run_done = 1'b1;
                    end
                end
            end else if (cell_done) begin
                chk(1'b0, "R8", "spurious cell_done", 1, 0);
            end
            word_stb = 1'b0;
            lat_expire = 1'b0;
            if (bus_gnt) begin
                bus_gnt = 1'b0;
                chk(!bus_req, "R7", "req dropped after grant", int'(bus_req), 0);
            end else if (bus_req) begin
                if (!req_prev) begin
                    req_rises++;
                    lag_cnt = gnt_lag;
                    held_len = int'(bus_len);
                    if (grp_words == 0) begin
                        if (have_start) begin
                            int sp;
                            sp = ncyc - last_start;
                            chk(sp % SLOT == 0 && sp >= SLOT, "R1", "start spacing on grid", sp, SLOT);
                            if (exact_ok) begin
                                int k, expv;
                                k = 1;
                                while (last_start + SLOT * k < last_done_n + 1) k++;
                                expv = SLOT * (k + prev_n);
                                if (prev_n == 0) chk(sp == expv, "R2", "single-cell spacing", sp, expv);
                                else             chk(sp == expv, "R3", "group spacing", sp, expv);
                                chk(cells_in_grp == ((prev_n == 0) ? 1 : prev_n), "R3",
                                    "cells per group", cells_in_grp, (prev_n == 0) ? 1 : prev_n);
                            end
                        end
                        cells_in_grp = 0;
                        prev_n = grp_of(int'(cfg_group));
                        grp_words = ((prev_n == 0) ? 1 : prev_n) * CW;
                        last_start = ncyc;
                        have_start = 1'b1;
                        exact_ok = 1'b1;
                    end
                end else begin
                    chk(int'(bus_len) == held_len, "R7", "len stable while waiting",
                        int'(bus_len), held_len);
                end
                if (lag_cnt == 0) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R4", "unexpected request", int'(bus_len), 0);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        chk(int'(bus_len) == e, "R4", "burst length", int'(bus_len), e);
                    end
                    burst_tb = int'(bus_len);
                    bus_gnt = 1'b1;
                end else begin
                    lag_cnt--;
                end
            end
            if (!bus_gnt && burst_tb > 0) begin
                word_stb = 1'b1;
                burst_tb--;
                cell_words--;
                grp_words--;
                last_of_cell = (cell_words == 0);
                if (lat_at > 0 && (CW - cell_words) == lat_at) begin
                    lat_expire = 1'b1;
                    burst_tb = 0;
                    lat_at = 0;
                end
            end
            req_prev = bus_req;
        end
    end

    // driver: queue expected bursts, release work, wait, check quiet window
    task automatic run(input int code, input int line, input bit frc,
                       input int groups, input int lat_w, input int lag, input string tag);
        int n, nc, cut;
        n = grp_of(code);
        nc = (n == 0) ? 1 : n;
        cut = (frc || line == 0 || line >= CW) ? CW : line;
        for (int g = 0; g < groups; g++) begin
            for (int c = 0; c < nc; c++) begin
                int rem;
                bit first;
                rem = CW;
                first = 1'b1;
                while (rem > 0) begin
                    int len;
                    len = (rem < cut) ? rem : cut;
                    exp_q.push_back(len);
                    if (first && lat_w > 0 && g == 0 && c == 0) rem -= lat_w;
                    else rem -= len;
                    first = 1'b0;
                end
            end
        end
        cfg_group = 3'(code);
        cfg_line_words = 4'(line);
        cfg_force_full = frc;
        lat_at = lat_w;
        gnt_lag = lag;
        target = done_cnt + groups * nc;
        run_done = 1'b0;
        exact_ok = 1'b0;
        work_pending = 1'b1;
        while (!run_done) @(negedge clk);
        chk(exp_q.size() == 0, tag, "all expected bursts seen", exp_q.size(), 0);
        begin
            int r0;
            r0 = req_rises;
            repeat (3 * SLOT) @(negedge clk);
            chk(req_rises == r0 && !bus_req, "R9", "no request while work low",
                req_rises - r0, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!bus_req, "R10", "bus_req in reset", int'(bus_req), 0);
        chk(!cell_done, "R10", "cell_done in reset", int'(cell_done), 0);
        rst_n = 1'b1;
        repeat (2 * SLOT) @(negedge clk);
        chk(!bus_req && req_rises == 0, "R9", "idle with no work", req_rises, 0);
        run(0, 4, 1'b0, 4, 0, 0, "R2");   // single cell, 4-word cut
        run(0, 5, 1'b0, 2, 0, 0, "R4");   // cut 5: 5,5,2
        run(0, 0, 1'b0, 2, 0, 0, "R4");   // line 0 means whole cell
        run(0, 4, 1'b1, 2, 0, 0, "R5");   // force full over line 4
        run(0, 4, 1'b0, 3, 0, 3, "R7");   // delayed grants
        run(2, 4, 1'b0, 3, 0, 0, "R3");   // group of 2
        run(1, 3, 1'b0, 3, 0, 0, "R3");   // group of 1, gap 1
        run(7, 4, 1'b1, 2, 0, 0, "R3");   // code 7 -> 5 cells
        run(6, 4, 1'b1, 2, 0, 0, "R3");   // code 6 saturates to 5
        run(0, 4, 1'b1, 2, 5, 0, "R6");   // latency split 12 -> 5 + 7
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule